// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset request of a chip into one system reset and keeps a readable record of what caused the last one. Five kinds of request feed it. The first is a power-good level from an analog detector. The second is an active-low external pin. The third is a software write strobe, which a separate disable bit can gate off. The fourth is a watchdog expiry pulse, and the fifth is one reset request line per voltage monitor. Each request gives the same result: the system reset goes low, stays low while the request lasts, and is then held low for a fixed stretch before it is released in step with the clock.

Power loss and the external pin pull the reset down at once, with no clock needed. Their release passes through a two-flop synchronizer. A sequencer with three states owns the output.
- `ST_HOLD`: some source is active.
- `ST_STRETCH`: all sources are quiet and a counter runs.
- `ST_RUN`: the system is out of reset.

The transitions are:
- HOLD→STRETCH when no source is active.
- STRETCH→HOLD when a source returns.
- STRETCH→RUN when the count reaches its end.
- RUN→HOLD on any source.
- Any state→HOLD asynchronously on power loss or on the pin.

The cause register is one-hot. Power loss alone returns it to the power-on code. Every other reset overwrites it with its own bit, so firmware reads it after the restart.

Top module: `rstc_top`

## Requirements
- R1: While `por_ok` is low, `sys_rst_n` is low and `rst_cause` reads 0x01 (bit 0 = power-on only); both take effect at once, with no clock edge.
- R2: After `por_ok` rises with no other source active, `sys_rst_n` rises at the 19th rising clock edge after the release and `rst_cause` still reads 0x01.
- R3: A low on `ext_rst_n` drives `sys_rst_n` low at once and holds it low while the pin stays low. After the pin returns high, `sys_rst_n` rises at the 19th rising edge. If the pin was low for at least 3 edges, `rst_cause` reads 0x02 (bit 1).
- R4: A `sw_req` strobe sampled high with `sw_dis` low drives `sys_rst_n` low after that edge. `sys_rst_n` rises at the 17th edge after the strobe edge, and `rst_cause` then reads 0x08 (bit 3).
- R5: A `sw_req` strobe sampled while `sw_dis` is high is ignored: `sys_rst_n` stays high and `rst_cause` is unchanged.
- R6: A `wdt_expire` pulse gives the R4 timing, and `rst_cause` reads 0x04 (bit 2).
- R7: A high on `mon_rst_req[i]` gives the R4 timing, and `rst_cause` reads bit 4+i alone.
- R8: A request that arrives during the post-release stretch restarts the hold. `sys_rst_n` rises at the 17th edge after the last edge that sampled a request, and the cause names that last request.
- R9: When several requests are sampled at one edge, the cause takes a single bit by priority: external pin (while held) first, then watchdog, then software, then the monitor with the lowest index. `rst_cause` always has exactly one bit set.
- R10: Non-power-on resets never clear the cause register. It keeps the last recorded bit through later idle time, and only a power-on event returns it to 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, running during reset |
| por_ok | input | 1 | Power-good level; low means power-on reset |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| sw_req | input | 1 | Software reset strobe (register write) |
| sw_dis | input | 1 | Disables the software reset path when high |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| mon_rst_req | input | NMON | Voltage-monitor reset requests, one per monitor |
| sys_rst_n | output | 1 | Synchronized active-low system reset |
| rst_cause | output | 4+NMON | One-hot reset-cause status |

## Verification
Synchronous requests are sampled at edge E0. `sys_rst_n` reads low from the falling edge after E0 and high only after E17. The bench therefore samples low at the falling edge after E16 and high at the one after E17. Asynchronous sources are checked 1 ns after they are driven, before any clock edge. Their release is counted from the first rising edge after the release: low after the 18th edge, high after the 19th. The cause is read once `sys_rst_n` is high again. It is compared with a bench function that applies the priority order to the inputs of the last active edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_e;

    // Cause bit positions, read by firmware
    localparam int CAUSE_POR   = 0;
    localparam int CAUSE_EXT   = 1;
    localparam int CAUSE_WDT   = 2;
    localparam int CAUSE_SW    = 3;
    localparam int CAUSE_FIXED = 4;  // first monitor bit
endpackage

// File: rtl/rstc_rel_sync.sv
// Release synchronizer: output clears at once on arst, sets after STAGES edges.
module rstc_rel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rel
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh_q <= '0;
        else      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end

    assign rel = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic rel,
    input  logic sync_req,
    output logic sys_rst_n
);
    localparam int CNT_W = $clog2(HOLD_CYC);
    localparam int QMAX  = HOLD_CYC + 2;
    localparam int QW    = $clog2(QMAX + 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic sys_rst_n_q;
    logic src_active;

    assign src_active = !rel || sync_req;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= ST_HOLD;
        else      state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!src_active) state_d = ST_STRETCH;
            ST_STRETCH: if (src_active) state_d = ST_HOLD;
                        else if (cnt_q == CNT_W'(HOLD_CYC - 1)) state_d = ST_RUN;
            ST_RUN:     if (src_active) state_d = ST_HOLD;
            default:    state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) cnt_q <= '0;
        else if (state_q == ST_STRETCH && state_d == ST_STRETCH) cnt_q <= cnt_q + 1'b1;
        else cnt_q <= '0;
    end

    // output register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) sys_rst_n_q <= 1'b0;
        else      sys_rst_n_q <= (state_d == ST_RUN);
    end

    assign sys_rst_n = sys_rst_n_q;

    // checker: edges since a source was last seen
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk or posedge arst) begin
        if (arst) quiet_q <= '0;
        else if (src_active) quiet_q <= '0;
        else if (quiet_q != QW'(QMAX)) quiet_q <= quiet_q + 1'b1;
    end

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (arst)
        $rose(sys_rst_n_q) |-> quiet_q == QW'(HOLD_CYC + 1)) else $error("release window"); // R8
    AST_REQ_ASSERTS_RESET: assert property (@(posedge clk) disable iff (arst)
        (sys_rst_n_q && sync_req) |=> !sys_rst_n_q) else $error("request ignored"); // R4
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
#(
    parameter int NMON   = 2,
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    por_arst,
    input  logic                    ext_rst_n,
    input  logic                    wdt_expire,
    input  logic                    sw_fire,
    input  logic                    sw_req,
    input  logic                    sw_dis,
    input  logic [NMON-1:0]         mon_req,
    output logic [CAUSE_FIXED+NMON-1:0] cause
);
    localparam int CW = CAUSE_FIXED + NMON;

    logic [STAGES-1:0] ext_s_q;
    logic [CW-1:0] cause_q, hit;
    logic          any_hit;

    always_ff @(posedge clk or posedge por_arst) begin
        if (por_arst) ext_s_q <= '1;
        else          ext_s_q <= {ext_s_q[STAGES-2:0], ext_rst_n};
    end

    always_comb begin
        hit     = '0;
        any_hit = 1'b1;
        if (!ext_s_q[STAGES-1])  hit[CAUSE_EXT] = 1'b1;
        else if (wdt_expire)     hit[CAUSE_WDT] = 1'b1;
        else if (sw_fire)        hit[CAUSE_SW]  = 1'b1;
        else if (|mon_req) begin
            for (int i = NMON - 1; i >= 0; i--) begin
                if (mon_req[i]) begin
                    hit = '0;
                    hit[CAUSE_FIXED + i] = 1'b1;
                end
            end
        end
        else any_hit = 1'b0;
    end

    always_ff @(posedge clk or posedge por_arst) begin
        if (por_arst)     cause_q <= CW'(1) << CAUSE_POR;
        else if (any_hit) cause_q <= hit;
    end

    assign cause = cause_q;

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (por_arst)
        $countones(cause_q) == 1) else $error("cause not one-hot"); // R9
    AST_SW_GATED: assert property (@(posedge clk) disable iff (por_arst)
        $rose(cause_q[CAUSE_SW]) |-> $past(sw_req && !sw_dis)) else $error("sw cause w/o enabled strobe"); // R5
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int NMON        = 2,
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      por_ok,
    input  logic                      ext_rst_n,
    input  logic                      sw_req,
    input  logic                      sw_dis,
    input  logic                      wdt_expire,
    input  logic [NMON-1:0]           mon_rst_req,
    output logic                      sys_rst_n,
    output logic [CAUSE_FIXED+NMON-1:0] rst_cause
);
    logic por_arst, arst, rel, sw_fire, sync_req;

    assign por_arst = !por_ok;
    assign arst     = !por_ok || !ext_rst_n;
    assign sw_fire  = sw_req && !sw_dis;
    assign sync_req = sw_fire || wdt_expire || (|mon_rst_req);

    rstc_rel_sync #(.STAGES(SYNC_STAGES)) u_rel (
        .clk (clk),
        .arst(arst),
        .rel (rel)
    );

    rstc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .arst     (arst),
        .rel      (rel),
        .sync_req (sync_req),
        .sys_rst_n(sys_rst_n)
    );

    rstc_cause #(.NMON(NMON), .STAGES(SYNC_STAGES)) u_cause (
        .clk       (clk),
        .por_arst  (por_arst),
        .ext_rst_n (ext_rst_n),
        .wdt_expire(wdt_expire),
        .sw_fire   (sw_fire),
        .sw_req    (sw_req),
        .sw_dis    (sw_dis),
        .mon_req   (mon_rst_req),
        .cause     (rst_cause)
    );
endmodule

// File: tb/rstc_top_tb_top.sv
`timescale 1ns/1ps
module rstc_top_tb_top;
    logic clk = 1'b0;
    logic por_ok = 1'b0, ext_rst_n = 1'b1, sw_req = 1'b0, sw_dis = 1'b0, wdt_expire = 1'b0;
    logic [1:0] mon_rst_req = '0;
    logic sys_rst_n;
    logic [5:0] rst_cause;
    logic [5:0] model_cause;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rstc_top #(.NMON(2), .HOLD_CYC(16), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_ok(por_ok), .ext_rst_n(ext_rst_n), .sw_req(sw_req),
        .sw_dis(sw_dis), .wdt_expire(wdt_expire), .mon_rst_req(mon_rst_req),
        .sys_rst_n(sys_rst_n), .rst_cause(rst_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_cause(input logic s, input logic w,
                                             input logic [1:0] m, input logic [5:0] prev);
        if (w)         return 6'b000100;
        else if (s)    return 6'b001000;
        else if (m[0]) return 6'b010000;
        else if (m[1]) return 6'b100000;
        else           return prev;
    endfunction

    // drive at a negedge, return at the negedge after the sampling edge
    task automatic fire(input logic s, input logic d, input logic w, input logic [1:0] m);
        sw_req = s; sw_dis = d; wdt_expire = w; mon_rst_req = m;
        @(negedge clk);
        sw_req = 0; sw_dis = 0; wdt_expire = 0; mon_rst_req = '0;
    endtask

    task automatic sync_release(input string req);
        repeat (16) @(negedge clk);
        chk({req, " low after E16"}, sys_rst_n, 0);
        @(negedge clk);
        chk({req, " high after E17"}, sys_rst_n, 1);
    endtask

    // called right after an async source is released at a negedge
    task automatic async_release(input string req);
        repeat (18) @(negedge clk);
        chk({req, " low after 18th edge"}, sys_rst_n, 0);
        @(negedge clk);
        chk({req, " high after 19th edge"}, sys_rst_n, 1);
    endtask

    task automatic run_sync(input string req, input logic s, input logic d,
                            input logic w, input logic [1:0] m);
        logic eff;
        logic [5:0] ec;
        eff = (s && !d) || w || (|m);
        ec  = exp_cause(s && !d, w, m, model_cause);
        fire(s, d, w, m);
        if (eff) begin
            chk({req, " asserted"}, sys_rst_n, 0);
            sync_release(req);
            chk({req, " cause"}, rst_cause, ec);
            model_cause = ec;
        end else begin
            chk({req, " R5 no reset"}, sys_rst_n, 1);
            chk({req, " R5 cause kept"}, rst_cause, model_cause);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        // R1 reset state
        repeat (5) @(negedge clk);
        chk("R1 rst low", sys_rst_n, 0);
        chk("R1 cause por", rst_cause, 6'h01);
        por_ok = 1;
        async_release("R2");
        chk("R2 cause por", rst_cause, 6'h01);
        model_cause = 6'h01;

        // directed sync sources
        run_sync("R4 sw", 1, 0, 0, 2'b00);
        run_sync("R5 sw disabled", 1, 1, 0, 2'b00);
        run_sync("R6 wdt", 0, 0, 1, 2'b00);
        run_sync("R7 mon1", 0, 0, 0, 2'b10);
        run_sync("R7 mon0", 0, 0, 0, 2'b01);
        run_sync("R9 wdt+sw+mon", 1, 0, 1, 2'b11);
        run_sync("R9 sw+mon1", 1, 0, 0, 2'b10);
        run_sync("R9 mon both", 0, 0, 0, 2'b11);

        // R8 retrigger during stretch
        fire(0, 0, 1, 2'b00);
        repeat (5) @(negedge clk);
        chk("R8 still low", sys_rst_n, 0);
        fire(1, 0, 0, 2'b00);
        sync_release("R8 retrigger");
        chk("R8 cause last", rst_cause, 6'h08);
        model_cause = 6'h08;

        // R3 external pin
        @(negedge clk);
        ext_rst_n = 0;
        #1 chk("R3 async low", sys_rst_n, 0);
        repeat (4) @(negedge clk);
        chk("R3 held", sys_rst_n, 0);
        ext_rst_n = 1;
        async_release("R3");
        chk("R3 cause ext", rst_cause, 6'h02);

        // R9 pin beats watchdog
        ext_rst_n = 0;
        repeat (4) @(negedge clk);
        wdt_expire = 1;
        @(negedge clk);
        wdt_expire = 0;
        @(negedge clk);
        ext_rst_n = 1;
        async_release("R9 ext+wdt");
        chk("R9 cause ext", rst_cause, 6'h02);
        model_cause = 6'h02;

        // random mix, R10 cause persistence
        for (int i = 0; i < 40; i++) begin
            logic s, d, w;
            logic [1:0] m;
            s = 1'($urandom % 2);
            d = 1'($urandom % 2);
            w = ($urandom % 4) == 0;
            m = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'b00;
            run_sync("R10 random", s, d, w, m);
            repeat ($urandom % 3) @(negedge clk);
            chk("R10 cause persists", rst_cause, model_cause);
        end

        // R10 only power-on clears
        @(negedge clk);
        por_ok = 0;
        #1 chk("R1 por async low", sys_rst_n, 0);
        chk("R10 por clears cause", rst_cause, 6'h01);
        repeat (3) @(negedge clk);
        por_ok = 1;
        async_release("R2 second");
        chk("R2 cause after por", rst_cause, 6'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule